// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block holds the on/off state of a crosspoint array with 4 rows and 8 columns, one storage bit per crosspoint, 32 bits in all. A single data bit is written into one cell at a time. The cell is chosen by a 3-bit column select and a 2-bit row select. A write is qualified by a chip select and a strobe. The block drives a 32-bit enable vector, one bit per crosspoint, and has no read-back path.

Each cell is a level-sensitive latch, not a flip-flop. While the strobe and the chip select are high, the selected cell is transparent and its enable follows the data input. The cell holds the value present on the data input when the strobe falls. An active-high master reset clears every cell at once, without a clock, whatever the chip select and strobe are doing. The analog switches themselves are outside this block. It models only the decode and the storage that steer them.

Top module: `xpoint_ctrl_mem`

## Requirements
- R1: While `rst` is 1, every bit of `sw_en` is 0, whatever the values of `cs`, `stb` and `din`.
- R2: A cell is written only when `cs`, `stb` and its own decode are all 1. With `cs` at 0, a strobe pulse leaves `sw_en` unchanged.
- R3: While `rst` is 0 and `cs` and `stb` are both 1, the selected enable bit follows `din`, rising and falling as `din` changes.
- R4: When `stb` falls, the selected cell keeps the value that `din` had just before the edge. Later changes of `din` do not affect it.
- R5: Writing 1 sets the selected enable bit, so that crosspoint is on. Writing 0 clears it, so that crosspoint is off.
- R6: A write alters only the selected bit. All other bits of `sw_en` keep their previous values.
- R7: If `rst` rises while `stb` is high, the selected bit goes to 0. If `rst` then falls while `cs` and `stb` are still high, that bit follows `din` again.
- R8: Bit `row_sel*8 + col_sel` of `sw_en` is the enable of the crosspoint at row `row_sel` and column `col_sel`. The column occupies the low 3 bits of that index.
- R9: Any number of crosspoints may be on at once. No row or column exclusivity is enforced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Master clear, active high, asynchronous |
| cs | input | 1 | Chip select, active high |
| stb | input | 1 | Write strobe; the cell is transparent while it is high and holds its value when it falls |
| din | input | 1 | Data bit shared by all cells |
| col_sel | input | 3 | Column select |
| row_sel | input | 2 | Row select |
| sw_en | output | 32 | Crosspoint enables, indexed row*8 + column |

## Verification
A master reset can land inside an open strobe window. The clear and the transparent write then act on the same cell at the same time. The bench provokes this by raising `rst` while `cs` and `stb` are high with `din` at 1, then releasing `rst` with the strobe still high. The output is judged against a behavioural model in which the clear wins while it is held and the write resumes once it is released. The capture at the strobe's falling edge also meets a data change in the following cycle. The model checks that the held value is the one that was present before the edge.

// File: rtl/xpoint_ctrl_mem.sv
module xpoint_ctrl_mem #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int N  = ROWS * COLS
) (
  input  logic          rst,
  input  logic          cs,
  input  logic          stb,
  input  logic          din,
  input  logic [CW-1:0] col_sel,
  input  logic [RW-1:0] row_sel,
  output logic [N-1:0]  sw_en
);

  logic [N-1:0] wr_en;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic cell_q;

      assign wr_en[IDX] = cs && stb && (row_sel == RW'(r)) && (col_sel == CW'(c));

      always_latch begin
        if (rst)              cell_q <= 1'b0;
        else if (wr_en[IDX])  cell_q <= din;
      end

      assign sw_en[IDX] = cell_q;
    end
  end

  logic [N-1:0] sel_mask;
  assign sel_mask = {{(N-1){1'b0}}, 1'b1} << (int'(row_sel) * COLS + int'(col_sel));

  assert_clear_rise_R1: assert property (@(posedge stb) rst |-> (sw_en == '0))
    else $error("R1: enables not clear under reset");

  assert_capture_R4: assert property (@(negedge stb) disable iff (rst)
    cs |-> ((sw_en & sel_mask) == (din ? sel_mask : '0)))
    else $error("R4: selected cell does not hold data at strobe fall");

  assert_only_selected_R6: assert property (@(negedge stb) disable iff (rst)
    (sw_en & ~sel_mask & ~$past(sw_en)) == '0)
    else $error("R6: unselected cell turned on");

  assert_cs_gate_R2: assert property (@(negedge stb) disable iff (rst)
    !cs |-> ((sw_en & ~$past(sw_en)) == '0))
    else $error("R2: cell turned on without chip select");

endmodule

// File: tb/xpoint_ctrl_mem_tb.sv
module xpoint_ctrl_mem_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0;
  logic stb = 1'b0;
  logic din = 1'b0;
  logic [2:0] col_sel = '0;
  logic [1:0] row_sel = '0;
  logic [31:0] sw_en;

  logic [31:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpoint_ctrl_mem dut_i (
    .rst(rst), .cs(cs), .stb(stb), .din(din),
    .col_sel(col_sel), .row_sel(row_sel), .sw_en(sw_en)
  );

  task automatic check_bit(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: bit=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step(input bit r, input bit c, input bit s, input bit d,
                      input int row, input int col, input string req);
    @(negedge clk);
    rst = r; cs = c; stb = s; din = d;
    row_sel = row[1:0]; col_sel = col[2:0];
    if (r) model = '0;
    else if (c && s) model[row*8 + col] = d;
    @(posedge clk);
    checks++;
    if (sw_en !== model) begin
      fails++;
      $display("FAIL %s: sw_en=%h expected %h", req, sw_en, model);
    end
  endtask

  task automatic write_cell(input int row, input int col, input bit d, input string req);
    step(0, 1, 0, d, row, col, req);
    step(0, 1, 1, d, row, col, req);
    step(0, 1, 0, d, row, col, req);
  endtask

  initial begin
    step(1, 1, 1, 1, 1, 1, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");

    // R3: transparency while strobe high
    step(0, 1, 0, 0, 2, 5, "R3");
    step(0, 1, 1, 1, 2, 5, "R3");
    step(0, 1, 1, 0, 2, 5, "R3");
    step(0, 1, 1, 1, 2, 5, "R3");
    // R4: capture at falling edge, later data ignored
    step(0, 1, 0, 1, 2, 5, "R4");
    step(0, 1, 0, 0, 2, 5, "R4");
    step(0, 0, 0, 0, 2, 5, "R4");
    check_bit(sw_en[21], 1'b1, "R8");

    // R2: strobe without chip select
    step(0, 0, 0, 1, 3, 7, "R2");
    step(0, 0, 1, 1, 3, 7, "R2");
    step(0, 0, 0, 1, 3, 7, "R2");
    check_bit(sw_en[31], 1'b0, "R2");

    // R5: write 0 turns off
    write_cell(2, 5, 0, "R5");
    check_bit(sw_en[21], 1'b0, "R5");

    // R6/R9: walk pattern over all cells
    for (int i = 0; i < 32; i++) write_cell(i / 8, i % 8, ((i * 7) % 3) != 0, "R6");
    for (int i = 0; i < 32; i += 3) write_cell(i / 8, i % 8, 1, "R9");
    check_bit($countones(sw_en) > 8, 1'b1, "R9");
    for (int i = 1; i < 32; i += 4) write_cell(i / 8, i % 8, 0, "R6");

    // R8: index mapping, row 1 col 0 -> bit 8, row 0 col 1 -> bit 1
    step(1, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    write_cell(1, 0, 1, "R8");
    check_bit(sw_en[8], 1'b1, "R8");
    check_bit(sw_en[1], 1'b0, "R8");

    // R7: reset during open strobe, then release
    step(0, 1, 0, 1, 3, 2, "R7");
    step(0, 1, 1, 1, 3, 2, "R7");
    step(1, 1, 1, 1, 3, 2, "R7");
    check_bit(sw_en[26], 1'b0, "R7");
    step(0, 1, 1, 1, 3, 2, "R7");
    check_bit(sw_en[26], 1'b1, "R7");
    step(0, 1, 1, 0, 3, 2, "R7");
    step(0, 1, 0, 1, 3, 2, "R7");

    // R1: reset with cells set clears everything
    write_cell(0, 7, 1, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule